// File: doc/BRIEF.md
# Sector Erase Batching Window

This block collects sector-erase requests from a flash command decoder into a batch and decides when the batch is final. The first sector-erase command opens an acceptance window that is counted in clock cycles. Each further sector-erase command that arrives while the window is open ORs its sector into a select mask and starts the window again from its full length. A falling-edge pulse of the write strobe also restarts it. When the window runs out with no new activity, the block sends a one-cycle start pulse to the erase sequencer. The accumulated mask is presented alongside that pulse.

If the decoder reports any other command while the window is open, the batch is dropped. The mask is cleared and a one-cycle abort pulse tells the surrounding logic to return to read mode. A status output reads 0 while the window is open and 1 at all other times, so software polling it can tell whether more sectors may still be added.

The window length is derived at elaboration from a clock-frequency parameter and a window length in microseconds (80 µs by default). The erase itself is carried out elsewhere.

Top module: `sector_erase_window`

## Requirements
- R1: A sector-erase command (`erase_cmd_i` high with `other_cmd_i` low) while the window is closed opens it. From the next cycle, `sector_mask_o` holds only bit `erase_sector_i` and `window_closed_o` reads 0.
- R2: Each sector-erase command while the window is open ORs bit `erase_sector_i` into `sector_mask_o`. Sectors may come in any order, and repeating a sector leaves the mask unchanged.
- R3: A `wr_fall_i` pulse while the window is open restarts the window from its full length. A `wr_fall_i` pulse while the window is closed has no effect on any output.
- R4: `erase_start_o` is high for exactly one cycle, WINDOW_CYC cycles after the last restarting input was sampled. In that cycle `sector_mask_o` still shows the batch and `window_closed_o` reads 1.
- R5: In the cycle after `erase_start_o`, `sector_mask_o` is zero. The exception is a sector-erase command sampled in the start cycle, which opens a fresh batch holding only its own sector.
- R6: `other_cmd_i` while the window is open clears `sector_mask_o`, closes the window and raises `abort_o` for one cycle, and no start follows. `other_cmd_i` wins over a sector-erase command sampled in the same cycle.
- R7: `other_cmd_i` while the window is closed has no effect on any output, and no abort pulse is raised.
- R8: During and after reset, `sector_mask_o` is 0, `erase_start_o` and `abort_o` are 0, and `window_closed_o` is 1.
- R9: WINDOW_CYC equals CLK_FREQ_HZ × WINDOW_US / 1,000,000, rounded up. This is 20 cycles for 250 kHz and 80 µs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| erase_cmd_i | input | 1 | One-cycle pulse: a sector-erase command was written |
| erase_sector_i | input | $clog2(NUM_SECTORS) | Sector index that goes with `erase_cmd_i` |
| wr_fall_i | input | 1 | One-cycle pulse on a falling edge of the write strobe |
| other_cmd_i | input | 1 | One-cycle pulse: a command other than sector erase was written |
| sector_mask_o | output | NUM_SECTORS | Accumulated sector-select mask |
| erase_start_o | output | 1 | One-cycle pulse: the batch is final and the erase may begin |
| abort_o | output | 1 | One-cycle pulse: the batch was dropped, return to read mode |
| window_closed_o | output | 1 | 0 while the window is open, 1 otherwise |

## Verification
The simplest pattern is a single command left to expire. It shows whether the window is counted to the exact cycle and whether the mask clears afterwards. Several commands, some repeating a sector and some arriving in scrambled order, tell true OR accumulation apart from overwriting. A strobe pulse placed late in the window tells a restart apart from a plain count-down. An other-command placed inside the window, outside it, and in the same cycle as an erase command tells an abort apart from an ignored input. Random streams of all three pulses then run against a bench model, so that collisions such as a new command landing on the expiry cycle or on the start cycle are covered.

// File: rtl/sew_pkg.sv
package sew_pkg;

   // Cycles in a window of win_us microseconds at hz, rounded up.
   function automatic longint unsigned sew_window_cycles(input longint unsigned hz,
                                                          input longint unsigned win_us);
      return (hz * win_us + 64'd999_999) / 64'd1_000_000;
   endfunction

   // Width needed to hold the value n.
   function automatic int unsigned sew_count_width(input longint unsigned n);
      int unsigned w;
      w = 1;
      while ((64'd1 << w) <= n) w++;
      return w;
   endfunction

endpackage

// File: rtl/sew_window_timer.sv
module sew_window_timer #(
   parameter int unsigned WINDOW_CYC = 20,
   parameter int unsigned CNT_W      = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart_i,
   input  logic cancel_i,
   output logic open_o,
   output logic expire_o
);

   generate
      if (WINDOW_CYC < 1) begin : g_bad_len
         $error("sew_window_timer: WINDOW_CYC must be at least 1");
      end
      if ((64'd1 << CNT_W) <= 64'(WINDOW_CYC)) begin : g_bad_w
         $error("sew_window_timer: CNT_W too small for WINDOW_CYC");
      end

      if (WINDOW_CYC == 1) begin : g_single
         // Single-cycle window: one flag is enough.
         logic open_q;
         always_ff @(posedge clk) begin
            if (!rst_n)         open_q <= 1'b0;
            else if (cancel_i)  open_q <= 1'b0;
            else                open_q <= restart_i;
         end
         assign open_o   = open_q;
         assign expire_o = open_q && !restart_i && !cancel_i;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                cnt_q <= '0;
            else if (cancel_i)         cnt_q <= '0;
            else if (restart_i)        cnt_q <= CNT_W'(WINDOW_CYC);
            else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
         end
         assign open_o   = (cnt_q != '0);
         assign expire_o = (cnt_q == CNT_W'(1)) && !restart_i && !cancel_i;

         p_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= CNT_W'(WINDOW_CYC));
         p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (restart_i && !cancel_i) |=> (cnt_q == CNT_W'(WINDOW_CYC)));
      end
   endgenerate

endmodule

// File: rtl/sew_ctrl.sv
module sew_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic erase_cmd_i,
   input  logic wr_fall_i,
   input  logic other_cmd_i,
   input  logic open_i,
   input  logic expire_i,
   output logic set_o,
   output logic restart_o,
   output logic cancel_o,
   output logic start_o,
   output logic abort_o
);

   logic start_q;
   logic abort_q;

   // An other-command outranks everything in the same cycle.
   assign set_o     = erase_cmd_i && !other_cmd_i;
   assign restart_o = set_o || (wr_fall_i && open_i && !other_cmd_i);
   assign cancel_o  = other_cmd_i && open_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= 1'b0;
         abort_q <= 1'b0;
      end else begin
         start_q <= expire_i;
         abort_q <= cancel_o;
      end
   end

   assign start_o = start_q;
   assign abort_o = abort_q;

   p_one_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |=> !start_q);
   p_one_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
      abort_q |=> !abort_q);
   p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_q && abort_q));

endmodule

// File: rtl/sew_sector_mask.sv
module sew_sector_mask #(
   parameter int unsigned NUM_SECTORS = 8,
   parameter int unsigned IDX_W       = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   set_i,
   input  logic [IDX_W-1:0]       idx_i,
   input  logic                   clear_i,
   output logic [NUM_SECTORS-1:0] mask_o
);

   generate
      if (NUM_SECTORS < 2) begin : g_bad_n
         $error("sew_sector_mask: NUM_SECTORS must be at least 2");
      end

      for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_bit
         logic hit;
         logic bit_q;
         assign hit = set_i && (idx_i == IDX_W'(s));
         always_ff @(posedge clk) begin
            if (!rst_n)        bit_q <= 1'b0;
            else if (clear_i)  bit_q <= hit;
            else if (hit)      bit_q <= 1'b1;
         end
         assign mask_o[s] = bit_q;
      end
   endgenerate

   p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_i |=> ((mask_o & $past(mask_o)) == $past(mask_o)));

endmodule

// File: rtl/sector_erase_window.sv
module sector_erase_window #(
   parameter int unsigned NUM_SECTORS = 8,
   parameter int unsigned CLK_FREQ_HZ = 125_000_000,
   parameter int unsigned WINDOW_US   = 80,
   localparam int unsigned IDX_W      = $clog2(NUM_SECTORS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   erase_cmd_i,
   input  logic [IDX_W-1:0]       erase_sector_i,
   input  logic                   wr_fall_i,
   input  logic                   other_cmd_i,
   output logic [NUM_SECTORS-1:0] sector_mask_o,
   output logic                   erase_start_o,
   output logic                   abort_o,
   output logic                   window_closed_o
);

   import sew_pkg::*;

   localparam longint unsigned WIN_L = sew_window_cycles(CLK_FREQ_HZ, WINDOW_US);
   localparam int unsigned WINDOW_CYC = int'(WIN_L);
   localparam int unsigned CNT_W      = sew_count_width(WIN_L);

   generate
      if (WIN_L < 1 || WIN_L > 64'hFFFF_FFFF) begin : g_bad_win
         $error("sector_erase_window: window length out of range");
      end
      if (WINDOW_US == 0) begin : g_bad_us
         $error("sector_erase_window: WINDOW_US must be nonzero");
      end
   endgenerate

   logic open_w;
   logic expire_w;
   logic set_w;
   logic restart_w;
   logic cancel_w;
   logic start_w;
   logic abort_w;

   sew_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .erase_cmd_i(erase_cmd_i),
      .wr_fall_i  (wr_fall_i),
      .other_cmd_i(other_cmd_i),
      .open_i     (open_w),
      .expire_i   (expire_w),
      .set_o      (set_w),
      .restart_o  (restart_w),
      .cancel_o   (cancel_w),
      .start_o    (start_w),
      .abort_o    (abort_w)
   );

   sew_window_timer #(
      .WINDOW_CYC(WINDOW_CYC),
      .CNT_W     (CNT_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart_i(restart_w),
      .cancel_i (cancel_w),
      .open_o   (open_w),
      .expire_o (expire_w)
   );

   sew_sector_mask #(
      .NUM_SECTORS(NUM_SECTORS),
      .IDX_W      (IDX_W)
   ) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_w),
      .idx_i  (erase_sector_i),
      .clear_i(cancel_w || start_w),
      .mask_o (sector_mask_o)
   );

   assign erase_start_o   = start_w;
   assign abort_o         = abort_w;
   assign window_closed_o = !open_w;

   p_closed_on_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      erase_start_o |-> window_closed_o);
   p_open_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !window_closed_o |-> (sector_mask_o != '0));
   p_clear_after_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_start_o && !erase_cmd_i) |=> (sector_mask_o == '0));
   p_abort_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(abort_o) |-> (sector_mask_o == '0 && window_closed_o));
   p_idle_other_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (other_cmd_i && window_closed_o) |=> !abort_o);

endmodule

// File: tb/sector_erase_window_tb.sv
module sector_erase_window_tb;

   localparam int unsigned NS     = 8;
   localparam int unsigned CLK_HZ = 250_000;
   localparam int unsigned WIN_US = 80;
   localparam int          W_EXP  = 20; // R9: 250 kHz x 80 us

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          erase_cmd = 1'b0;
   logic [2:0]    erase_sec = '0;
   logic          wr_fall = 1'b0;
   logic          other_cmd = 1'b0;
   logic [NS-1:0] mask;
   logic          start;
   logic          abort;
   logic          closed;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   // Bench model state
   int          m_cnt;
   logic [7:0]  m_mask;
   bit          m_start;
   bit          m_abort;

   always #4 clk = ~clk; // 125 MHz

   sector_erase_window #(
      .NUM_SECTORS(NS),
      .CLK_FREQ_HZ(CLK_HZ),
      .WINDOW_US  (WIN_US)
   ) u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .erase_cmd_i    (erase_cmd),
      .erase_sector_i (erase_sec),
      .wr_fall_i      (wr_fall),
      .other_cmd_i    (other_cmd),
      .sector_mask_o  (mask),
      .erase_start_o  (start),
      .abort_o        (abort),
      .window_closed_o(closed)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] next_mask(input logic [7:0] cur, input bit prev_start,
                                             input bit set, input logic [2:0] idx);
      logic [7:0] b;
      b = prev_start ? 8'h00 : cur;
      if (set) b = b | (8'h01 << idx);
      return b;
   endfunction

   task automatic model_step(input bit e, input logic [2:0] s, input bit w, input bit o);
      bit op;
      bit set;
      op  = (m_cnt != 0);
      set = e && !o;
      if (o && op) begin
         m_abort = 1; m_start = 0; m_mask = 8'h00; m_cnt = 0;
      end else begin
         m_abort = 0;
         m_mask  = next_mask(m_mask, m_start, set, s);
         if (set || (w && op)) begin
            m_cnt = W_EXP; m_start = 0;
         end else if (op && m_cnt == 1) begin
            m_cnt = 0; m_start = 1;
         end else begin
            if (op) m_cnt--;
            m_start = 0;
         end
      end
   endtask

   task automatic step(input bit e, input logic [2:0] s, input bit w, input bit o);
      erase_cmd = e; erase_sec = s; wr_fall = w; other_cmd = o;
      @(posedge clk);
      model_step(e, s, w, o);
      @(negedge clk);
      erase_cmd = 0; wr_fall = 0; other_cmd = 0;
      chk("R2 mask", 32'(mask), 32'(m_mask));
      chk("R4 start", 32'(start), 32'(m_start));
      chk("R6 abort", 32'(abort), 32'(m_abort));
      chk("R3 status", 32'(closed), 32'(m_cnt == 0));
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 3'd0, 0, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int waited;
      void'($urandom(32'd20240611));
      m_cnt = 0; m_mask = 0; m_start = 0; m_abort = 0;
      repeat (3) @(negedge clk);
      // R8: reset state
      chk("R8 mask", 32'(mask), 0);
      chk("R8 start", 32'(start), 0);
      chk("R8 abort", 32'(abort), 0);
      chk("R8 status", 32'(closed), 1);
      rst_n = 1'b1;
      idle(2);

      // R1, R9, R4, R5: single sector left to expire
      step(1, 3'd3, 0, 0);
      chk("R1 mask", 32'(mask), 32'h08);
      chk("R1 status", 32'(closed), 0);
      waited = 0;
      while (!start && waited < 100) begin idle(1); waited++; end
      chk("R9 window", waited, W_EXP);
      chk("R4 mask at start", 32'(mask), 32'h08);
      chk("R4 status at start", 32'(closed), 1);
      idle(1);
      chk("R5 cleared", 32'(mask), 0);

      // R2: scrambled order and repeats
      step(1, 3'd5, 0, 0);
      step(1, 3'd1, 0, 0);
      step(1, 3'd5, 0, 0);
      idle(4);
      step(1, 3'd7, 0, 0);
      chk("R2 accum", 32'(mask), 32'hA2);
      idle(W_EXP);
      chk("R2 start", 32'(start), 1);
      chk("R2 batch", 32'(mask), 32'hA2);
      idle(1);

      // R3: strobe late in window restarts it; strobe when closed ignored
      step(0, 3'd0, 1, 0);
      chk("R3 idle strobe", 32'(closed), 1);
      step(1, 3'd2, 0, 0);
      idle(W_EXP - 5);
      step(0, 3'd0, 1, 0);
      waited = 0;
      while (!start && waited < 100) begin idle(1); waited++; end
      chk("R3 restart", waited, W_EXP);
      idle(2);

      // R6: other command inside window
      step(1, 3'd4, 0, 0);
      idle(5);
      step(0, 3'd0, 0, 1);
      chk("R6 abort", 32'(abort), 1);
      chk("R6 mask", 32'(mask), 0);
      chk("R6 status", 32'(closed), 1);
      waited = 0;
      for (int i = 0; i < W_EXP + 5; i++) begin idle(1); if (start) waited++; end
      chk("R6 no start", waited, 0);
      // R6: other wins over same-cycle erase
      step(1, 3'd6, 0, 0);
      step(1, 3'd0, 0, 1);
      chk("R6 priority", 32'(mask), 0);

      // R7: other command while closed
      idle(2);
      step(0, 3'd0, 0, 1);
      chk("R7 no abort", 32'(abort), 0);
      chk("R7 status", 32'(closed), 1);
      chk("R7 mask", 32'(mask), 0);

      // R5: new command in the start cycle begins a fresh batch
      step(1, 3'd6, 0, 0);
      while (!start) idle(1);
      step(1, 3'd0, 0, 0);
      chk("R5 fresh", 32'(mask), 32'h01);
      chk("R5 reopen", 32'(closed), 0);
      idle(W_EXP + 2);

      // Random mix against the model
      for (int i = 0; i < 4000; i++) begin
         bit e, w, o;
         e = ($urandom % 100) < 8;
         w = ($urandom % 100) < 8;
         o = ($urandom % 100) < 2;
         step(e, 3'($urandom % NS), w, o);
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule